// File: doc/BRIEF.md
# Cascaded BCH-CRC Memory Scrub Controller

This block is a background sequencer that keeps a protected memory array clean. At a programmable interval it walks every address of the array. For each word it hands the stored 63-bit BCH codeword to an external BCH decoder and the codeword together with its 16 CRC check bits to an external CRC checker. The BCH decoder, the re-encoder and the CRC arithmetic sit outside the block. Each one is reached through its own request/acknowledge handshake.

The controller acts on the combined verdict. A word that both checks accept is left alone. A word the BCH decoder repairs is not written back straight away. Its corrected 51 data bits are re-encoded, and the new codeword is parked in a spare scratch word together with the CRC bits that were stored at the original address. That scratch word is then read back and checked against the old CRC. The original address is overwritten only if this check passes. Words that fail this cross-check, and words the BCH decoder accepts but the CRC rejects, are classed as multi-bit failures. Their addresses are queued in a small FIFO that other logic can drain.

Top module: `scrub_ctrl`

## Requirements
- R1: While reset is high, and on the first cycle after it, there is no memory request, both counters read zero, and the bad-address FIFO is empty with its overflow flag clear. The pass-done output is low.
- R2: A word that both decoders accept (no BCH error, no CRC error) causes no memory write at all, and neither counter changes.
- R3: A memory word is {CRC[15:0] in bits 78:63, BCH codeword in bits 62:0}. For a word the BCH decoder flags as corrected, the controller writes {stored CRC bits, re-encoded codeword of the corrected data} to SPARE_ADDR. It makes this write before any write to an address inside the array.
- R4: If the CRC check of the spare word read back from SPARE_ADDR passes, the original address is overwritten with that spare word and the corrected-word counter rises by one.
- R5: If that CRC check fails, the original address is not written. Its address is pushed into the bad-address FIFO and the marked-word counter rises by one.
- R6: A word that the BCH decoder accepts but the CRC checker rejects is not written. Its address is marked in the same way as in R5.
- R7: Each pass reads addresses 0 to NUM_WORDS-1 once each, in ascending order. After the last address is handled, pass_done_o is high for exactly one cycle.
- R8: A pass starts only when no pass is running and at least interval_i clock cycles have elapsed since the previous pass started (or since reset). With a pass shorter than the interval, consecutive passes start interval_i+1 cycles apart.
- R9: The bad-address FIFO holds FIFO_DEPTH (8) entries and presents the oldest entry first. An entry is removed when bad_valid_o and bad_ready_i are both high at a clock edge.
- R10: A push into a full FIFO is dropped and sets bad_ovf_o, which stays set until reset. The marked-word counter still counts that word.
- R11: A request to the BCH decoder, re-encoder or CRC checker stays high with a stable operand until its acknowledge is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| interval_i | input | INT_W | Minimum cycles between pass starts |
| mem_req_o | output | 1 | Memory request strobe |
| mem_we_o | output | 1 | Write enable qualifying mem_req_o |
| mem_addr_o | output | ADDR_W | Memory address |
| mem_wdata_o | output | CRC_W+CW_W | Memory write word |
| mem_rvalid_i | input | 1 | Read data valid |
| mem_rdata_i | input | CRC_W+CW_W | Read data word |
| bdec_req_o | output | 1 | BCH decode request |
| bdec_cw_o | output | CW_W | Codeword to decode |
| bdec_ack_i | input | 1 | BCH decode done |
| bdec_err_i | input | 1 | BCH decoder corrected an error |
| bdec_data_i | input | DATA_W | Corrected data bits |
| benc_req_o | output | 1 | BCH re-encode request |
| benc_data_o | output | DATA_W | Data to re-encode |
| benc_ack_i | input | 1 | Re-encode done |
| benc_cw_i | input | CW_W | Re-encoded codeword |
| crc_req_o | output | 1 | CRC check request |
| crc_cw_o | output | CW_W | Codeword under check |
| crc_bits_o | output | CRC_W | CRC bits to compare against |
| crc_ack_i | input | 1 | CRC check done |
| crc_err_i | input | 1 | CRC mismatch |
| bad_valid_o | output | 1 | FIFO holds a marked address |
| bad_addr_o | output | ADDR_W | Oldest marked address |
| bad_ready_i | input | 1 | Consumer takes the head entry |
| bad_ovf_o | output | 1 | Sticky FIFO overflow |
| corr_cnt_o | output | CNT_W | Words repaired |
| mark_cnt_o | output | CNT_W | Words marked as multi-bit failures |
| pass_done_o | output | 1 | One-cycle end-of-pass pulse |

## Verification
The hardest situation to reach from the ports is a BCH decoder that claims a successful correction but returns wrong data. Only the spare-word CRC cross-check can catch that case, and it must then suppress the write-back. The bench's behavioural decoder stub takes a per-test substitute data word, so a miscorrection can be ordered on demand. A second hard case is a corrupted CRC field under a word that the BCH decoder repairs correctly; the bench injects that too. FIFO overflow needs more marked words than the FIFO can hold within one pass. The bench corrupts the CRC field of ten addresses while the consumer holds bad_ready_i low.

// File: rtl/scrub_pkg.sv
package scrub_pkg;
  localparam int DATA_BITS = 51;
  localparam int CODE_BITS = 63;
  localparam int CHK_BITS  = 16;

  typedef enum logic [3:0] {
    S_IDLE, S_RD, S_RWAIT, S_BDEC, S_CDEC, S_ENC, S_SPW,
    S_SPR, S_SPRW, S_CHK, S_WB, S_MARK, S_NEXT
  } scrub_state_e;
endpackage

// File: rtl/scrub_timer.sv
module scrub_timer #(
  parameter int INT_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             restart,
  input  logic [INT_W-1:0] interval,
  output logic             expired
);
  logic [INT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || restart) cnt_q <= '0;
    else if (cnt_q != '1) cnt_q <= cnt_q + INT_W'(1);
  end

  assign expired = (cnt_q >= interval);
endmodule

// File: rtl/bad_fifo.sv
module bad_fifo #(
  parameter int DEPTH  = 8,
  parameter int DATA_W = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              push_i,
  input  logic [DATA_W-1:0] push_data_i,
  input  logic              pop_i,
  output logic              valid_o,
  output logic [DATA_W-1:0] data_o,
  output logic              ovf_o
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [DATA_W-1:0] store [DEPTH];
  logic [PW-1:0]     wptr_q, rptr_q;
  logic [CW-1:0]     count_q;
  logic              full, do_push, do_pop;

  assign full    = (count_q == CW'(DEPTH));
  assign do_pop  = pop_i && (count_q != '0);
  assign do_push = push_i && (!full || do_pop);

  always_ff @(posedge clk) begin
    if (do_push) store[wptr_q] <= push_data_i;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wptr_q  <= '0;
      rptr_q  <= '0;
      count_q <= '0;
      ovf_o   <= 1'b0;
    end else begin
      if (do_push) wptr_q <= (wptr_q == PW'(DEPTH - 1)) ? '0 : wptr_q + PW'(1);
      if (do_pop)  rptr_q <= (rptr_q == PW'(DEPTH - 1)) ? '0 : rptr_q + PW'(1);
      if (do_push && !do_pop)      count_q <= count_q + CW'(1);
      else if (do_pop && !do_push) count_q <= count_q - CW'(1);
      if (push_i && !do_push) ovf_o <= 1'b1;
    end
  end

  assign valid_o = (count_q != '0);
  assign data_o  = store[rptr_q];
endmodule

// File: rtl/scrub_ctrl.sv
module scrub_ctrl #(
  parameter int DATA_W     = scrub_pkg::DATA_BITS,
  parameter int CW_W       = scrub_pkg::CODE_BITS,
  parameter int CRC_W      = scrub_pkg::CHK_BITS,
  parameter int ADDR_W     = 5,
  parameter int NUM_WORDS  = 16,
  parameter int SPARE_ADDR = 16,
  parameter int INT_W      = 32,
  parameter int FIFO_DEPTH = 8,
  parameter int CNT_W      = 16
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [INT_W-1:0]       interval_i,
  output logic                   mem_req_o,
  output logic                   mem_we_o,
  output logic [ADDR_W-1:0]      mem_addr_o,
  output logic [CRC_W+CW_W-1:0]  mem_wdata_o,
  input  logic                   mem_rvalid_i,
  input  logic [CRC_W+CW_W-1:0]  mem_rdata_i,
  output logic                   bdec_req_o,
  output logic [CW_W-1:0]        bdec_cw_o,
  input  logic                   bdec_ack_i,
  input  logic                   bdec_err_i,
  input  logic [DATA_W-1:0]      bdec_data_i,
  output logic                   benc_req_o,
  output logic [DATA_W-1:0]      benc_data_o,
  input  logic                   benc_ack_i,
  input  logic [CW_W-1:0]        benc_cw_i,
  output logic                   crc_req_o,
  output logic [CW_W-1:0]        crc_cw_o,
  output logic [CRC_W-1:0]       crc_bits_o,
  input  logic                   crc_ack_i,
  input  logic                   crc_err_i,
  output logic                   bad_valid_o,
  output logic [ADDR_W-1:0]      bad_addr_o,
  input  logic                   bad_ready_i,
  output logic                   bad_ovf_o,
  output logic [CNT_W-1:0]       corr_cnt_o,
  output logic [CNT_W-1:0]       mark_cnt_o,
  output logic                   pass_done_o
);
  import scrub_pkg::*;

  localparam int WORD_W = CRC_W + CW_W;
  localparam logic [ADDR_W-1:0] LAST  = ADDR_W'(NUM_WORDS - 1);
  localparam logic [ADDR_W-1:0] SPARE = ADDR_W'(SPARE_ADDR);

  scrub_state_e      state_q;
  logic [ADDR_W-1:0] addr_q;
  logic [WORD_W-1:0] word_q, spare_q;
  logic              bch_err_q;
  logic              expired, restart;

  // stored CRC field of the word being scrubbed
  logic [CRC_W-1:0]  old_crc;
  assign old_crc = word_q[WORD_W-1 -: CRC_W];
  assign bdec_cw_o = word_q[CW_W-1:0];

  assign restart = (state_q == S_IDLE) && expired;

  scrub_timer #(.INT_W(INT_W)) u_timer (
    .clk(clk), .rst(rst), .restart(restart),
    .interval(interval_i), .expired(expired)
  );

  bad_fifo #(.DEPTH(FIFO_DEPTH), .DATA_W(ADDR_W)) u_fifo (
    .clk(clk), .rst(rst),
    .push_i(state_q == S_MARK), .push_data_i(addr_q),
    .pop_i(bad_ready_i), .valid_o(bad_valid_o),
    .data_o(bad_addr_o), .ovf_o(bad_ovf_o)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q     <= S_IDLE;
      addr_q      <= '0;
      word_q      <= '0;
      spare_q     <= '0;
      bch_err_q   <= 1'b0;
      mem_req_o   <= 1'b0;
      mem_we_o    <= 1'b0;
      mem_addr_o  <= '0;
      mem_wdata_o <= '0;
      bdec_req_o  <= 1'b0;
      benc_req_o  <= 1'b0;
      benc_data_o <= '0;
      crc_req_o   <= 1'b0;
      crc_cw_o    <= '0;
      crc_bits_o  <= '0;
      corr_cnt_o  <= '0;
      mark_cnt_o  <= '0;
      pass_done_o <= 1'b0;
    end else begin
      pass_done_o <= 1'b0;
      case (state_q)
        S_IDLE: if (expired) begin
          addr_q     <= '0;
          mem_req_o  <= 1'b1;
          mem_we_o   <= 1'b0;
          mem_addr_o <= '0;
          state_q    <= S_RD;
        end
        S_RD: begin
          mem_req_o <= 1'b0;
          state_q   <= S_RWAIT;
        end
        S_RWAIT: if (mem_rvalid_i) begin
          word_q     <= mem_rdata_i;
          crc_cw_o   <= mem_rdata_i[CW_W-1:0];
          crc_bits_o <= mem_rdata_i[WORD_W-1 -: CRC_W];
          bdec_req_o <= 1'b1;
          state_q    <= S_BDEC;
        end
        S_BDEC: if (bdec_ack_i) begin
          bdec_req_o  <= 1'b0;
          bch_err_q   <= bdec_err_i;
          benc_data_o <= bdec_data_i;
          crc_req_o   <= 1'b1;
          state_q     <= S_CDEC;
        end
        S_CDEC: if (crc_ack_i) begin
          crc_req_o <= 1'b0;
          if (bch_err_q) begin
            benc_req_o <= 1'b1;
            state_q    <= S_ENC;
          end else if (crc_err_i) begin
            state_q <= S_MARK;
          end else begin
            state_q <= S_NEXT;
          end
        end
        S_ENC: if (benc_ack_i) begin
          benc_req_o  <= 1'b0;
          mem_req_o   <= 1'b1;
          mem_we_o    <= 1'b1;
          mem_addr_o  <= SPARE;
          mem_wdata_o <= {old_crc, benc_cw_i};
          state_q     <= S_SPW;
        end
        S_SPW: begin
          // read the trial word back from the scratch location
          mem_req_o  <= 1'b1;
          mem_we_o   <= 1'b0;
          mem_addr_o <= SPARE;
          state_q    <= S_SPR;
        end
        S_SPR: begin
          mem_req_o <= 1'b0;
          state_q   <= S_SPRW;
        end
        S_SPRW: if (mem_rvalid_i) begin
          spare_q    <= mem_rdata_i;
          crc_cw_o   <= mem_rdata_i[CW_W-1:0];
          crc_bits_o <= old_crc;
          crc_req_o  <= 1'b1;
          state_q    <= S_CHK;
        end
        S_CHK: if (crc_ack_i) begin
          crc_req_o <= 1'b0;
          if (!crc_err_i) begin
            mem_req_o   <= 1'b1;
            mem_we_o    <= 1'b1;
            mem_addr_o  <= addr_q;
            mem_wdata_o <= spare_q;
            corr_cnt_o  <= corr_cnt_o + CNT_W'(1);
            state_q     <= S_WB;
          end else begin
            state_q <= S_MARK;
          end
        end
        S_WB: begin
          mem_req_o <= 1'b0;
          mem_we_o  <= 1'b0;
          state_q   <= S_NEXT;
        end
        S_MARK: begin
          mark_cnt_o <= mark_cnt_o + CNT_W'(1);
          state_q    <= S_NEXT;
        end
        S_NEXT: begin
          if (addr_q == LAST) begin
            pass_done_o <= 1'b1;
            state_q     <= S_IDLE;
          end else begin
            addr_q     <= addr_q + ADDR_W'(1);
            mem_req_o  <= 1'b1;
            mem_we_o   <= 1'b0;
            mem_addr_o <= addr_q + ADDR_W'(1);
            state_q    <= S_RD;
          end
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/scrub_ctrl_chk.sv
module scrub_ctrl_chk #(
  parameter int CW_W       = 63,
  parameter int CRC_W      = 16,
  parameter int ADDR_W     = 5,
  parameter int NUM_WORDS  = 16,
  parameter int SPARE_ADDR = 16,
  parameter int INT_W      = 32
) (
  input logic                  clk,
  input logic                  rst,
  input logic [INT_W-1:0]      interval_i,
  input logic                  mem_req_o,
  input logic                  mem_we_o,
  input logic [ADDR_W-1:0]     mem_addr_o,
  input logic [CRC_W+CW_W-1:0] mem_wdata_o,
  input logic                  bdec_req_o,
  input logic                  bdec_ack_i,
  input logic [CW_W-1:0]       bdec_cw_o,
  input logic                  crc_req_o,
  input logic                  crc_ack_i,
  input logic                  bad_ovf_o,
  input logic                  pass_done_o
);
  logic                  spare_seen;
  logic [CRC_W+CW_W-1:0] spare_data;
  logic [INT_W-1:0]      gap;
  logic                  wr_spare, wr_range, rd_first;

  assign wr_spare = mem_req_o && mem_we_o && (mem_addr_o == ADDR_W'(SPARE_ADDR));
  assign wr_range = mem_req_o && mem_we_o && (mem_addr_o < ADDR_W'(NUM_WORDS));
  assign rd_first = mem_req_o && !mem_we_o && (mem_addr_o == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      spare_seen <= 1'b0;
      spare_data <= '0;
      gap        <= '0;
    end else begin
      if (wr_spare) begin
        spare_seen <= 1'b1;
        spare_data <= mem_wdata_o;
      end else if (wr_range) begin
        spare_seen <= 1'b0;
      end
      if (rd_first) gap <= '0;
      else if (gap != '1) gap <= gap + INT_W'(1);
    end
  end

  assert_spare_first_R3: assert property (@(posedge clk) disable iff (rst)
    wr_range |-> spare_seen);

  assert_wb_is_spare_R4: assert property (@(posedge clk) disable iff (rst)
    wr_range |-> (mem_wdata_o == spare_data));

  assert_done_pulse_R7: assert property (@(posedge clk) disable iff (rst)
    pass_done_o |=> !pass_done_o);

  assert_start_gap_R8: assert property (@(posedge clk) disable iff (rst)
    rd_first |-> (gap >= interval_i));

  assert_ovf_sticky_R10: assert property (@(posedge clk) disable iff (rst)
    bad_ovf_o |=> bad_ovf_o);

  assert_bdec_hold_R11: assert property (@(posedge clk) disable iff (rst)
    (bdec_req_o && !bdec_ack_i) |=> (bdec_req_o && $stable(bdec_cw_o)));

  assert_crc_hold_R11: assert property (@(posedge clk) disable iff (rst)
    (crc_req_o && !crc_ack_i) |=> crc_req_o);
endmodule

bind scrub_ctrl scrub_ctrl_chk #(
  .CW_W(CW_W), .CRC_W(CRC_W), .ADDR_W(ADDR_W), .NUM_WORDS(NUM_WORDS),
  .SPARE_ADDR(SPARE_ADDR), .INT_W(INT_W)
) u_chk (
  .clk(clk), .rst(rst), .interval_i(interval_i),
  .mem_req_o(mem_req_o), .mem_we_o(mem_we_o), .mem_addr_o(mem_addr_o),
  .mem_wdata_o(mem_wdata_o), .bdec_req_o(bdec_req_o), .bdec_ack_i(bdec_ack_i),
  .bdec_cw_o(bdec_cw_o), .crc_req_o(crc_req_o), .crc_ack_i(crc_ack_i),
  .bad_ovf_o(bad_ovf_o), .pass_done_o(pass_done_o)
);

// File: tb/tb_scrub_ctrl.sv
module tb_scrub_ctrl;
  localparam int NW = 16;
  localparam int AW = 5;
  localparam int SP = 16;
  localparam int IV = 300;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] interval = 32'(IV);
  logic        mem_req, mem_we, mem_rvalid;
  logic [AW-1:0] mem_addr;
  logic [78:0] mem_wdata, mem_rdata;
  logic        bdec_req, bdec_ack, bdec_err;
  logic [62:0] bdec_cw;
  logic [50:0] bdec_data;
  logic        benc_req, benc_ack;
  logic [50:0] benc_data;
  logic [62:0] benc_cw;
  logic        crc_req, crc_ack, crc_err;
  logic [62:0] crc_cw;
  logic [15:0] crc_bits;
  logic        bad_valid, bad_ready, bad_ovf, pass_done;
  logic [AW-1:0] bad_addr;
  logic [15:0] corr_cnt, mark_cnt;

  always #10 clk = ~clk;

  scrub_ctrl dut (
    .clk(clk), .rst(rst), .interval_i(interval),
    .mem_req_o(mem_req), .mem_we_o(mem_we), .mem_addr_o(mem_addr),
    .mem_wdata_o(mem_wdata), .mem_rvalid_i(mem_rvalid), .mem_rdata_i(mem_rdata),
    .bdec_req_o(bdec_req), .bdec_cw_o(bdec_cw), .bdec_ack_i(bdec_ack),
    .bdec_err_i(bdec_err), .bdec_data_i(bdec_data),
    .benc_req_o(benc_req), .benc_data_o(benc_data), .benc_ack_i(benc_ack),
    .benc_cw_i(benc_cw),
    .crc_req_o(crc_req), .crc_cw_o(crc_cw), .crc_bits_o(crc_bits),
    .crc_ack_i(crc_ack), .crc_err_i(crc_err),
    .bad_valid_o(bad_valid), .bad_addr_o(bad_addr), .bad_ready_i(bad_ready),
    .bad_ovf_o(bad_ovf), .corr_cnt_o(corr_cnt), .mark_cnt_o(mark_cnt),
    .pass_done_o(pass_done)
  );

  // behavioural code models
  function automatic logic [11:0] par12(input logic [50:0] d);
    return d[11:0] ^ d[23:12] ^ d[35:24] ^ d[47:36] ^ {9'd0, d[50:48]};
  endfunction
  function automatic logic [62:0] enc(input logic [50:0] d);
    return {d, par12(d)};
  endfunction
  function automatic logic [15:0] crcf(input logic [62:0] c);
    return c[15:0] ^ {c[30:16], c[31]} ^ c[47:32] ^ {1'b0, c[62:48]};
  endfunction
  function automatic logic [50:0] gd(input int a);
    return 51'h5_1234_5678_9ABC ^ (51'(a) << 20) ^ (51'(a) * 51'h1_0101);
  endfunction
  function automatic logic [78:0] gword(input int a);
    return {crcf(enc(gd(a))), enc(gd(a))};
  endfunction

  logic [50:0] fix_data = '0;
  always_comb begin
    bdec_err  = (bdec_cw[11:0] != par12(bdec_cw[62:12]));
    bdec_data = bdec_err ? fix_data : bdec_cw[62:12];
    benc_cw   = enc(benc_data);
    crc_err   = (crc_bits != crcf(crc_cw));
  end

  always @(posedge clk) begin
    bdec_ack <= bdec_req & ~bdec_ack;
    benc_ack <= benc_req & ~benc_ack;
    crc_ack  <= crc_req & ~crc_ack;
  end

  // memory model and monitor
  logic [78:0] mem [32];
  int cyc = 0, rng_wr = 0, order_err = 0, rd_err = 0, exp_rd = 0;
  int start_cyc = 0, gap_last = 0;
  bit spare_seen = 0;

  always @(posedge clk) begin
    cyc = cyc + 1;
    mem_rvalid <= 1'b0;
    if (!rst && mem_req) begin
      if (mem_we) begin
        mem[mem_addr] <= mem_wdata;
        if (int'(mem_addr) < NW) begin
          rng_wr = rng_wr + 1;
          if (!spare_seen) order_err = order_err + 1;
          spare_seen = 0;
        end
        if (int'(mem_addr) == SP) spare_seen = 1;
      end else begin
        mem_rdata  <= mem[mem_addr];
        mem_rvalid <= 1'b1;
        if (mem_addr == '0) begin
          gap_last  = cyc - start_cyc;
          start_cyc = cyc;
          exp_rd    = 0;
        end
        if (int'(mem_addr) < NW) begin
          if (int'(mem_addr) != exp_rd) rd_err = rd_err + 1;
          exp_rd = exp_rd + 1;
        end
      end
    end
  end

  int checks = 0, fails = 0;
  task automatic check(input bit ok, input string tag, input string what,
                       input logic [79:0] act, input logic [79:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  always @(posedge clk) begin
    if (cyc > 150000) begin
      checks++; fails++;
      $display("FAIL R7 watchdog: actual %0d cycles expected under 150000", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  // {addr[4:0], kind[2:0], expect corrected, expect marked}
  // kind: 0 clean, 1 data bit flip, 2 parity bit flip, 3 CRC field flip,
  //       4 data flip with miscorrecting decoder, 5 data flip plus CRC flip
  localparam logic [9:0] VEC [8] = '{
    {5'd3,  3'd0, 1'b0, 1'b0},
    {5'd0,  3'd1, 1'b1, 1'b0},
    {5'd15, 3'd2, 1'b1, 1'b0},
    {5'd7,  3'd3, 1'b0, 1'b1},
    {5'd9,  3'd4, 1'b0, 1'b1},
    {5'd4,  3'd5, 1'b0, 1'b1},
    {5'd15, 3'd1, 1'b1, 1'b0},
    {5'd0,  3'd3, 1'b0, 1'b1}
  };

  function automatic logic [78:0] inject(input logic [78:0] w, input int kind);
    case (kind)
      1, 4: return w ^ (79'd1 << 42);
      2:    return w ^ 79'd1;
      3:    return w ^ (79'd1 << 63);
      5:    return w ^ (79'd1 << 42) ^ (79'd1 << 63);
      default: return w;
    endcase
  endfunction

  task automatic load_clean();
    for (int a = 0; a < 32; a++) mem[a] = (a < NW) ? gword(a) : '0;
    rng_wr = 0; order_err = 0; rd_err = 0;
  endtask

  task automatic wait_pass();
    do @(negedge clk); while (!pass_done);
  endtask

  task automatic pop_one();
    bad_ready = 1'b1;
    @(negedge clk);
    bad_ready = 1'b0;
  endtask

  initial begin
    int exp_corr, exp_mark, a, kind;
    logic [78:0] stored, exp_word;
    bad_ready = 1'b0;
    exp_corr = 0; exp_mark = 0;
    load_clean();
    repeat (3) @(negedge clk);
    check(!mem_req && corr_cnt == 0 && mark_cnt == 0, "R1", "reset req/counters",
          {mem_req, corr_cnt, mark_cnt}, 0);
    check(!bad_valid && !bad_ovf && !pass_done, "R1", "reset fifo/done",
          {bad_valid, bad_ovf, pass_done}, 0);
    rst = 1'b0;
    @(negedge clk);
    check(!mem_req && corr_cnt == 0, "R1", "first cycle after reset", mem_req, 0);

    for (int v = 0; v < 8; v++) begin
      a = int'(VEC[v][9:5]); kind = int'(VEC[v][4:2]);
      load_clean();
      stored = inject(gword(a), kind);
      mem[a] = stored;
      fix_data = gd(a) ^ ((kind == 4) ? 51'd1 : 51'd0);
      exp_corr += int'(VEC[v][1]);
      exp_mark += int'(VEC[v][0]);
      wait_pass();
      exp_word = (kind <= 2) ? gword(a) : stored;
      check(mem[a] === exp_word, (kind == 3) ? "R6" : (kind >= 4 ? "R5" : "R4"),
            $sformatf("vec %0d word at %0d", v, a), mem[a], exp_word);
      check(rng_wr == int'(VEC[v][1]), (kind == 0) ? "R2" : "R5",
            $sformatf("vec %0d in-array writes", v), rng_wr, VEC[v][1]);
      if (kind == 1 || kind == 2 || kind >= 4)
        check(mem[SP] === {stored[78:63], enc(fix_data)}, "R3",
              $sformatf("vec %0d spare word", v), mem[SP], {stored[78:63], enc(fix_data)});
      check(order_err == 0, "R3", $sformatf("vec %0d spare before write-back", v), order_err, 0);
      check(rd_err == 0, "R7", $sformatf("vec %0d read order", v), rd_err, 0);
      check(corr_cnt == 16'(exp_corr), "R4", $sformatf("vec %0d corrected count", v),
            corr_cnt, exp_corr);
      check(mark_cnt == 16'(exp_mark), "R5", $sformatf("vec %0d marked count", v),
            mark_cnt, exp_mark);
      if (VEC[v][0]) begin
        check(bad_valid && bad_addr == AW'(a), "R9", $sformatf("vec %0d fifo head", v),
              {bad_valid, bad_addr}, {1'b1, 5'(a)});
        pop_one();
      end
      check(!bad_valid, "R9", $sformatf("vec %0d fifo empty", v), bad_valid, 0);
      @(negedge clk);
      check(!pass_done, "R7", $sformatf("vec %0d done pulse width", v), pass_done, 0);
    end
    check(gap_last >= IV && gap_last <= IV + 2, "R8", "start spacing", gap_last, IV + 1);

    // ten CRC-corrupted words overfill the eight-entry FIFO
    load_clean();
    for (int i = 0; i < 10; i++) mem[i] = inject(gword(i), 3);
    wait_pass();
    check(bad_ovf, "R10", "overflow flag", bad_ovf, 1);
    check(mark_cnt == 16'(exp_mark + 10), "R10", "marks counted past overflow",
          mark_cnt, exp_mark + 10);
    check(corr_cnt == 16'(exp_corr), "R6", "no repair on CRC-only fault", corr_cnt, exp_corr);
    check(rng_wr == 0, "R6", "no writes on CRC-only fault", rng_wr, 0);
    for (int i = 0; i < 8; i++) begin
      check(bad_valid && bad_addr == AW'(i), "R9", $sformatf("drain entry %0d", i),
            {bad_valid, bad_addr}, {1'b1, 5'(i)});
      pop_one();
    end
    check(!bad_valid, "R9", "fifo empty after drain", bad_valid, 0);
    repeat (20) @(negedge clk);
    check(bad_ovf, "R10", "overflow still set", bad_ovf, 1);

    // short interval: pass length dominates the spacing
    rst = 1'b1;
    interval = 32'd5;
    load_clean();
    repeat (2) @(negedge clk);
    check(!bad_ovf && mark_cnt == 0 && corr_cnt == 0, "R1", "second reset clears state",
          {bad_ovf, mark_cnt, corr_cnt}, 0);
    rst = 1'b0;
    wait_pass();
    wait_pass();
    check(gap_last >= 7 * NW, "R8", "no start before pass end", gap_last, 7 * NW);
    check(rng_wr == 0 && mark_cnt == 0 && corr_cnt == 0, "R2", "clean passes leave memory",
          {rng_wr, mark_cnt, corr_cnt}, 0);
    check(rd_err == 0, "R7", "read order short interval", rd_err, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule